// File: doc/BRIEF.md
# Packed 16-bit Dot Product Unit

This block is a two-stage pipelined datapath for a 128-bit vector unit. Each of the two source vectors holds eight signed 16-bit lanes. The unit multiplies the matching lanes at full 32-bit precision. It then adds each even/odd pair of products into one of four 32-bit result lanes. A second opcode makes the unit also add the matching 32-bit lane of a third vector to each pair sum.

Operations enter through a valid/ready handshake. An accepted operation has its products registered at the first clock edge. The pair reduction and the optional accumulate are registered at the second edge. The unit takes one new operation per cycle while the output side keeps up. When the output side applies backpressure, the pipeline stalls in place and loses nothing. An opcode that is not one of the two defined codes produces an all-zero result with an illegal-opcode flag.

Top module: `vdot16_unit`

## Requirements
- R1: Lane k of a 16-bit vector sits at bits [16k+15:16k] and lane j of a 32-bit vector at bits [32j+31:32j]. With opcode 0xdb, result lane j is the signed 32-bit product of source lanes 2j plus the signed product of source lanes 2j+1, and the products are not truncated.
- R2: With opcode 0xdc, each result lane equals the R1 pair sum plus lane j of opC. This is identical to a 32-bit lane-wise add of the 0xdb result and opC.
- R3: All 32-bit additions wrap modulo 2^32 with no saturation. When both pairs of a lane are 0x8000 times 0x8000, that lane reads 0x80000000.
- R4: Any opcode other than 0xdb or 0xdc yields a result of all zeros with illegalOp high. illegalOp is high only while outValid presents such a result, so with outReady high it lasts one cycle.
- R5: Suppose an operation is accepted at a rising edge (inValid and inReady both high) and outReady is high at the following edge. Its result is then presented with outValid high after that second edge, which is a latency of two cycles. With outReady held high, inReady stays high and the unit accepts one operation every cycle.
- R6: While outValid is high and outReady is low, result, illegalOp and outValid hold. If both stages are full and stalled, inReady is low. Every accepted operation is delivered exactly once, and in order.
- R7: During and immediately after reset, outValid and illegalOp are low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An operation is offered |
| inReady | output | 1 | The unit can accept an operation this cycle |
| opcode | input | 8 | Operation select: 0xdb dot product, 0xdc dot product with accumulate |
| opA | input | 128 | First source vector, eight signed 16-bit lanes |
| opB | input | 128 | Second source vector, eight signed 16-bit lanes |
| opC | input | 128 | Accumulate vector, four 32-bit lanes (used by 0xdc only) |
| outValid | output | 1 | A result is presented |
| outReady | input | 1 | The consumer takes the presented result |
| result | output | 128 | Four 32-bit result lanes |
| illegalOp | output | 1 | The presented result came from an undefined opcode |

## Verification
The assertions check the handshake behaviour on every cycle:
- A stalled result, together with its valid and illegal flags, holds.
- illegalOp never appears without outValid, and it always comes with a zero result.
- The two-cycle latency holds whenever the output is not stalled.
- The doubled most-negative product case wraps to 0x80000000.

The arithmetic itself can only be shown by the bench's scenarios. These cover:
- the lane ordering and the signed widening of products;
- accumulation, including overflow of the 32-bit add;
- in-order delivery under random backpressure;
- inReady dropping when both stages are full.

// File: rtl/vdot_pkg.sv
package vdot_pkg;

  localparam logic [7:0] OPC_DOT    = 8'hdb;
  localparam logic [7:0] OPC_DOTACC = 8'hdc;

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,
    KIND_ACC   = 2'd1,
    KIND_BAD   = 2'd2
  } opKind_t;

  typedef struct packed {
    logic loadProd;
    logic loadSum;
    logic useAcc;
    logic zeroOut;
  } dpStrobe_t;

  function automatic opKind_t decodeOp(input logic [7:0] opc);
    if (opc == OPC_DOT)         return KIND_PLAIN;
    else if (opc == OPC_DOTACC) return KIND_ACC;
    else                        return KIND_BAD;
  endfunction

endpackage

// File: rtl/vdot_ctrl.sv
module vdot_ctrl
  import vdot_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [OPC_W-1:0] opcode,
  output logic             outValid,
  input  logic             outReady,
  output logic             illegalOp,
  output dpStrobe_t        strb
);

  logic    prodValid;
  opKind_t prodKind;
  logic    sumValid;
  logic    sumBad;
  logic    advSum;
  logic    advProd;
  opKind_t inKind;

  assign inKind  = decodeOp(8'(opcode));
  assign advSum  = !sumValid || outReady;
  assign advProd = !prodValid || advSum;
  assign inReady = advProd;

  always_comb begin
    strb          = '0;
    strb.loadProd = inValid && advProd;
    strb.loadSum  = prodValid && advSum;
    strb.useAcc   = (prodKind == KIND_ACC);
    strb.zeroOut  = (prodKind == KIND_BAD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodValid <= 1'b0;
      prodKind  <= KIND_PLAIN;
      sumValid  <= 1'b0;
      sumBad    <= 1'b0;
    end else begin
      if (advProd) begin
        prodValid <= inValid;
        if (inValid) prodKind <= inKind;
      end
      if (advSum) begin
        sumValid <= prodValid;
        if (prodValid) sumBad <= (prodKind == KIND_BAD);
      end
    end
  end

  assign outValid  = sumValid;
  assign illegalOp = sumValid && sumBad;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(illegalOp))); // R6

  AST_ILLEGAL_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> outValid); // R4

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && prodValid) |-> !inReady); // R6

endmodule

// File: rtl/vdot_dp.sv
module vdot_dp
  import vdot_pkg::*;
#(
  parameter int OUT_LANES = 4,
  parameter int IN_W      = 16,
  parameter int OUT_W     = 32,
  localparam int IN_LANES = OUT_LANES * 2,
  localparam int VEC_W    = IN_LANES * IN_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic [VEC_W-1:0] opC,
  output logic [VEC_W-1:0] result
);

  logic [OUT_W-1:0] prodNext [IN_LANES];
  logic [OUT_W-1:0] prodQ    [IN_LANES];
  logic [VEC_W-1:0] accQ;
  logic [VEC_W-1:0] resQ;
  logic [VEC_W-1:0] sumNext;

  for (genvar k = 0; k < IN_LANES; k++) begin : g_mul
    logic signed [IN_W-1:0]  lhs;
    logic signed [IN_W-1:0]  rhs;
    logic signed [OUT_W-1:0] full;
    assign lhs = opA[k*IN_W +: IN_W];
    assign rhs = opB[k*IN_W +: IN_W];
    assign full = OUT_W'(lhs) * OUT_W'(rhs);
    assign prodNext[k] = full;

    always_ff @(posedge clk) begin
      if (!rstN)             prodQ[k] <= '0;
      else if (strb.loadProd) prodQ[k] <= prodNext[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              accQ <= '0;
    else if (strb.loadProd) accQ <= opC;
  end

  for (genvar j = 0; j < OUT_LANES; j++) begin : g_red
    logic [OUT_W-1:0] pairSum;
    logic [OUT_W-1:0] addend;
    assign pairSum = prodQ[2*j] + prodQ[2*j+1];
    assign addend  = strb.useAcc ? accQ[j*OUT_W +: OUT_W] : '0;
    assign sumNext[j*OUT_W +: OUT_W] = strb.zeroOut ? '0 : (pairSum + addend);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             resQ <= '0;
    else if (strb.loadSum) resQ <= sumNext;
  end

  assign result = resQ;

  AST_MIN_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadSum && !strb.useAcc && !strb.zeroOut &&
     prodQ[0] == (OUT_W'(1) << (OUT_W-2)) && prodQ[1] == (OUT_W'(1) << (OUT_W-2)))
    |=> (result[OUT_W-1:0] == (OUT_W'(1) << (OUT_W-1)))); // R3

endmodule

// File: rtl/vdot16_unit.sv
module vdot16_unit
  import vdot_pkg::*;
#(
  parameter int OUT_LANES = 4,
  parameter int IN_W      = 16,
  parameter int OUT_W     = 32,
  parameter int OPC_W     = 8,
  localparam int VEC_W    = OUT_LANES * 2 * IN_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [OPC_W-1:0] opcode,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic [VEC_W-1:0] opC,
  output logic             outValid,
  input  logic             outReady,
  output logic [VEC_W-1:0] result,
  output logic             illegalOp
);

  dpStrobe_t strb;

  vdot_ctrl #(.OPC_W(OPC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opcode(opcode), .outValid(outValid), .outReady(outReady),
    .illegalOp(illegalOp), .strb(strb)
  );

  vdot_dp #(.OUT_LANES(OUT_LANES), .IN_W(IN_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .opA(opA), .opB(opB), .opC(opC), .result(result)
  );

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (result == '0)); // R4

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(result)); // R6

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid && inReady, 2) && $past(outReady, 1)) |-> outValid); // R5

endmodule

// File: tb/sim_vdot16_unit.sv
`timescale 1ns/1ps
module sim_vdot16_unit;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [7:0]   opcode = 8'h00;
  logic [127:0] opA = '0, opB = '0, opC = '0;
  logic         outValid;
  logic         outReady = 1'b1;
  logic [127:0] result;
  logic         illegalOp;

  vdot16_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opcode(opcode), .opA(opA), .opB(opB), .opC(opC),
    .outValid(outValid), .outReady(outReady), .result(result),
    .illegalOp(illegalOp)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;
  bit done   = 0;

  logic [127:0] expRes [1024];
  logic         expBad [1024];
  int           expCyc [1024];
  bit           expLat [1024];
  int wrPtr = 0, rdPtr = 0;
  bit latMode = 0;

  bit           prevStall = 0;
  logic [127:0] prevRes;
  logic         prevIll;

  always @(posedge clk) cycle <= cycle + 1;

  function automatic logic [128:0] model(input logic [7:0] op, input logic [127:0] a,
                                         input logic [127:0] b, input logic [127:0] c);
    logic [127:0] r;
    r = '0;
    if (op != 8'hdb && op != 8'hdc) return {1'b1, 128'h0};
    for (int j = 0; j < 4; j++) begin
      logic signed [31:0] p0, p1;
      logic [31:0] s;
      p0 = 32'($signed(a[32*j +: 16])) * 32'($signed(b[32*j +: 16]));
      p1 = 32'($signed(a[32*j+16 +: 16])) * 32'($signed(b[32*j+16 +: 16]));
      s = 32'(p0) + 32'(p1);
      if (op == 8'hdc) s = s + c[32*j +: 32];
      r[32*j +: 32] = s;
    end
    return {1'b0, r};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit iv, input logic [7:0] op, input logic [127:0] a,
                      input logic [127:0] b, input logic [127:0] c, input bit ordy,
                      output bit fired, output bit rdySeen);
    logic [128:0] m;
    @(negedge clk);
    inValid = iv; opcode = op; opA = a; opB = b; opC = c; outReady = ordy;
    #1;
    rdySeen = inReady;
    fired = iv && inReady;
    if (prevStall) begin
      check(outValid && result == prevRes && illegalOp == prevIll, "R6 hold",
            result, prevRes);
    end
    if (!outValid) check(!illegalOp, "R4 flag without result", 128'(illegalOp), 128'h0);
    if (outValid && outReady) begin
      if (rdPtr == wrPtr) check(0, "R6 extra output", result, 128'h0);
      else begin
        check(result == expRes[rdPtr[9:0]], expRes[rdPtr[9:0]] == 0 ? "R1/R4 result" : "R1 R2 R3 result",
              result, expRes[rdPtr[9:0]]);
        check(illegalOp == expBad[rdPtr[9:0]], "R4 flag", 128'(illegalOp),
              128'(expBad[rdPtr[9:0]]));
        if (expLat[rdPtr[9:0]])
          check(cycle - expCyc[rdPtr[9:0]] == 2, "R5 latency",
                128'(cycle - expCyc[rdPtr[9:0]]), 128'd2);
        rdPtr = (rdPtr + 1) % 1024;
      end
    end
    prevStall = outValid && !outReady;
    prevRes = result;
    prevIll = illegalOp;
    if (fired) begin
      m = model(op, a, b, c);
      expRes[wrPtr[9:0]] = m[127:0];
      expBad[wrPtr[9:0]] = m[128];
      expCyc[wrPtr[9:0]] = cycle;
      expLat[wrPtr[9:0]] = latMode;
      wrPtr = (wrPtr + 1) % 1024;
    end
  endtask

  task automatic push(input logic [7:0] op, input logic [127:0] a, input logic [127:0] b,
                      input logic [127:0] c);
    bit f, r;
    f = 0;
    while (!f) step(1, op, a, b, c, 1, f, r);
  endtask

  task automatic drain();
    bit f, r;
    for (int i = 0; i < 6; i++) step(0, 8'h00, '0, '0, '0, 1, f, r);
    check(rdPtr == wrPtr, "R6 all delivered", 128'(rdPtr), 128'(wrPtr));
  endtask

  function automatic logic [15:0] pick16();
    int s = $urandom % 8;
    case (s)
      0: return 16'h8000;
      1: return 16'h7fff;
      2: return 16'hffff;
      3: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [127:0] rvec16();
    logic [127:0] v;
    for (int k = 0; k < 8; k++) v[16*k +: 16] = pick16();
    return v;
  endfunction

  function automatic logic [127:0] rvec32();
    logic [127:0] v;
    for (int k = 0; k < 4; k++) v[32*k +: 32] = ($urandom % 4 == 0) ? 32'h7fffffff : $urandom;
    return v;
  endfunction

  function automatic logic [7:0] rop();
    int s = $urandom % 10;
    if (s < 4) return 8'hdb;
    if (s < 9) return 8'hdc;
    return 8'($urandom);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    bit f, r;
    int acc;
    logic [127:0] a, b;
    int unused;
    unused = $urandom(32'd2468);
    repeat (3) @(negedge clk);
    #1;
    check(!outValid && !illegalOp && inReady, "R7 in reset", {outValid, illegalOp, inReady}, 3'b001);
    @(negedge clk); rstN = 1'b1;
    #1;
    check(!outValid && !illegalOp && inReady, "R7 after reset", {outValid, illegalOp, inReady}, 3'b001);

    // R1 lane ordering and signed widening
    latMode = 1;
    a = '0; b = '0;
    for (int k = 0; k < 8; k++) begin a[16*k +: 16] = 16'(k + 1); b[16*k +: 16] = 16'(100 * (k + 1)); end
    push(8'hdb, a, b, '0);
    push(8'hdb, {8{16'hffff}}, {8{16'h7fff}}, '0);
    // R2 accumulate
    push(8'hdc, a, b, {32'd10, 32'hffffffff, 32'd3, 32'h80000000});
    // R3 most-negative squared pairs
    push(8'hdb, {8{16'h8000}}, {8{16'h8000}}, '0);
    push(8'hdc, {8{16'h8000}}, {8{16'h8000}}, {4{32'h80000000}});
    push(8'hdc, {8{16'h7fff}}, {8{16'h7fff}}, {4{32'h7fffffff}});
    // R4 illegal opcodes
    push(8'hda, a, b, {4{32'h1}});
    push(8'h00, {8{16'h8000}}, b, '0);
    push(8'hdb, a, b, '0);
    drain();
    latMode = 0;

    // R6 stall fills both stages then blocks inReady
    acc = 0;
    for (int i = 0; i < 5; i++) begin
      step(1, 8'hdc, rvec16(), rvec16(), rvec32(), 0, f, r);
      if (acc >= 2) check(!r, "R6 inReady low when full", 128'(r), 128'h0);
      if (f) acc++;
    end
    check(acc == 2, "R6 accepted count under stall", 128'(acc), 128'd2);
    drain();

    // R5 back-to-back throughput
    latMode = 1;
    for (int i = 0; i < 60; i++) begin
      step(1, rop(), rvec16(), rvec16(), rvec32(), 1, f, r);
      check(r, "R5 inReady while flowing", 128'(r), 128'h1);
    end
    drain();
    latMode = 0;

    // random traffic with backpressure
    for (int i = 0; i < 1500; i++)
      step(($urandom % 4) != 0, rop(), rvec16(), rvec16(), rvec32(), ($urandom % 3) != 0, f, r);
    drain();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule